// File: doc/BRIEF.md
# Core Test Wrapper Serial Logic

This block wraps an embedded core for scan-style testing. A serial instruction register picks the wrapper's mode. A one-bit bypass register and a chain of boundary cells form the data paths. Each boundary cell sits on one functional signal: the input cells are on the pins that feed the core, and the output cells are on the core's outputs that drive the pins. Serial data enters on `wsi` and leaves on `wso`.

No state machine sequences the wrapper. Four discrete strobes (capture, shift, update, transfer) and an instruction/data select line qualify each event directly on the rising edge of the wrapper clock `wrck`. An active-low asynchronous reset returns the wrapper to the transparent functional mode.

The supported modes are:
- bypass
- external interconnect test
- internal core test
- preload
- clamp
- safe-state

Top module: `core_wrapper_serial`

## Requirements
- R1: While `wrstn` is low the instruction becomes BYPASS (000) at once, and all shift and update storage and `wso` read 0. The functional paths are then transparent.
- R2: With `sel_ir`=1, the instruction register acts on the strobes. Capture loads the pattern `CAPT_PAT` (default 3'b110). Shift moves `wsi` into bit 2 and each bit one place toward bit 0, which feeds `wso`. Update makes the shifted value the active instruction. Opcodes are BYPASS 000, EXTEST 001, INTEST 010, PRELOAD 011, CLAMP 100 and SAFE 101; 110 and 111 act as BYPASS.
- R3: Under BYPASS, `core_in` equals `pin_in` and `pin_out` equals `core_out`. The data path is the one-bit bypass register, which captures 0.
- R4: In the boundary chain, cells 0..N_IN-1 sit on `pin_in`/`core_in` bit k and cells N_IN..N_IN+N_OUT-1 sit on `core_out`/`pin_out` bit k-N_IN. `wsi` feeds cell 0, the last cell feeds `wso`, and each shift moves the chain by one cell.
- R5: Update copies each cell's shift storage into its update storage. Shifting never alters `pin_out` or `core_in`.
- R6: Under EXTEST, `pin_out` comes from the output cells' update storage. On capture, input cells take `pin_in` and output cells take their own `pin_out`.
- R7: Under INTEST, `core_in` comes from the input cells' update storage. On capture, output cells take `core_out` and input cells take their own `core_in`.
- R8: Under PRELOAD the boundary chain is selected and both functional paths stay transparent. On capture, cells take `pin_in` and `core_out`.
- R9: Under CLAMP, `pin_out` comes from the output cells' update storage, `core_in` equals `pin_in`, and the bypass register is the data path.
- R10: Under SAFE, `pin_out` equals `SAFE_VAL` whatever `core_out` is, `core_in` equals `pin_in`, and the bypass register is the data path.
- R11: With the boundary chain selected, a transfer loads each cell's update storage back into its shift storage.
- R12: If more than one of capture, shift, update and transfer is high at a rising edge, no storage changes.
- R13: `wso` changes only on the falling edge of `wrck`. It carries instruction bit 0, the last boundary cell or the bypass bit, according to the path selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrck | input | 1 | Wrapper clock |
| wrstn | input | 1 | Asynchronous reset, active low |
| sel_ir | input | 1 | 1 selects the instruction register, 0 the data register |
| capture_wr | input | 1 | Capture strobe |
| shift_wr | input | 1 | Shift strobe |
| update_wr | input | 1 | Update strobe |
| transfer_wr | input | 1 | Transfer strobe |
| wsi | input | 1 | Serial data in |
| wso | output | 1 | Serial data out, changes on falling edge |
| pin_in | input | N_IN | Chip-side signals bound for the core |
| core_in | output | N_IN | Signals delivered to the core inputs |
| core_out | input | N_OUT | Core output signals |
| pin_out | output | N_OUT | Signals delivered to the chip side |

## Verification
The bench builds the wrapper with three input cells, three output cells and a safe value of 3'b101. With only six chain positions, every value on each functional side (eight per side) can be swept under each mode. A chain scan-out can be compared against a vector the bench computes by bit arithmetic, for example a right shift by one for the bypass path. The small sizes also let the bench check clamp, safe-state, transfer readback, asynchronous reset and strobe collisions against the values it last loaded.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int IR_W = 3;

  typedef enum logic [IR_W-1:0] {
    OP_BYPASS  = 3'b000,
    OP_EXTEST  = 3'b001,
    OP_INTEST  = 3'b010,
    OP_PRELOAD = 3'b011,
    OP_CLAMP   = 3'b100,
    OP_SAFE    = 3'b101
  } cw_op_e;

  // Number of active strobes in a strobe vector.
  function automatic int strobe_count(input logic [3:0] s);
    int n;
    n = 0;
    for (int i = 0; i < 4; i++) n += int'(s[i]);
    return n;
  endfunction

  function automatic logic lone_strobe(input logic [3:0] s);
    return strobe_count(s) == 1;
  endfunction

  // Boundary chain sits between wsi and wso for these opcodes.
  function automatic logic uses_chain(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_INTEST) || (op == OP_PRELOAD);
  endfunction

  function automatic logic drives_pins(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_CLAMP);
  endfunction

  function automatic logic drives_core(input logic [IR_W-1:0] op);
    return op == OP_INTEST;
  endfunction

  function automatic logic is_safe(input logic [IR_W-1:0] op);
    return op == OP_SAFE;
  endfunction
endpackage

// File: rtl/cw_instr_reg.sv
module cw_instr_reg
  import cw_pkg::*;
#(
  parameter logic [IR_W-1:0] CAPT_PAT = 3'b110
) (
  input  logic            wrck,
  input  logic            wrstn,
  input  logic            ev_cap,
  input  logic            ev_sh,
  input  logic            ev_upd,
  input  logic            wsi,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_q
);
  logic [IR_W-1:0] sh_next;

  always_comb begin
    sh_next = ir_sh;
    if (ev_cap)     sh_next = CAPT_PAT;
    else if (ev_sh) sh_next = {wsi, ir_sh[IR_W-1:1]};
  end

  always_ff @(posedge wrck or negedge wrstn) begin
    if (!wrstn) ir_sh <= '0;
    else        ir_sh <= sh_next;
  end

  always_ff @(posedge wrck or negedge wrstn) begin
    if (!wrstn)      ir_q <= OP_BYPASS;
    else if (ev_upd) ir_q <= ir_sh;
  end

  AST_IR_CAPTURE: assert property (@(posedge wrck) disable iff (!wrstn)
    ev_cap |=> ir_sh == CAPT_PAT); // R2
  AST_IR_SHIFT: assert property (@(posedge wrck) disable iff (!wrstn)
    ev_sh |=> ir_sh == {$past(wsi), $past(ir_sh[IR_W-1:1])}); // R2
  AST_IR_UPDATE: assert property (@(posedge wrck) disable iff (!wrstn)
    ev_upd |=> ir_q == $past(ir_sh)); // R2
endmodule

// File: rtl/cw_bypass_bit.sv
module cw_bypass_bit (
  input  logic wrck,
  input  logic wrstn,
  input  logic ev_cap,
  input  logic ev_sh,
  input  logic wsi,
  output logic byp_q
);
  always_ff @(posedge wrck or negedge wrstn) begin
    if (!wrstn)      byp_q <= 1'b0;
    else if (ev_cap) byp_q <= 1'b0;
    else if (ev_sh)  byp_q <= wsi;
  end

  AST_BYP_CAPTURE: assert property (@(posedge wrck) disable iff (!wrstn)
    ev_cap |=> !byp_q); // R3
  AST_BYP_SHIFT: assert property (@(posedge wrck) disable iff (!wrstn)
    ev_sh |=> byp_q == $past(wsi)); // R3
endmodule

// File: rtl/cw_cell.sv
module cw_cell (
  input  logic wrck,
  input  logic wrstn,
  input  logic cti,
  input  logic cfi,
  input  logic ev_cap,
  input  logic ev_sh,
  input  logic ev_upd,
  input  logic ev_xfer,
  input  logic drive,
  input  logic cap_cfo,
  input  logic force_safe,
  input  logic safe_bit,
  output logic cfo,
  output logic cto,
  output logic upd_q
);
  logic sh_q;
  logic up_q;
  logic cap_val;

  assign cfo     = force_safe ? safe_bit : (drive ? up_q : cfi);
  assign cap_val = cap_cfo ? cfo : cfi;
  assign cto     = sh_q;
  assign upd_q   = up_q;

  always_ff @(posedge wrck or negedge wrstn) begin
    if (!wrstn)       sh_q <= 1'b0;
    else if (ev_cap)  sh_q <= cap_val;
    else if (ev_sh)   sh_q <= cti;
    else if (ev_xfer) sh_q <= up_q;
  end

  always_ff @(posedge wrck or negedge wrstn) begin
    if (!wrstn)      up_q <= 1'b0;
    else if (ev_upd) up_q <= sh_q;
  end

  AST_CELL_SHIFT: assert property (@(posedge wrck) disable iff (!wrstn)
    ev_sh |=> cto == $past(cti)); // R4
  AST_CELL_UPDATE: assert property (@(posedge wrck) disable iff (!wrstn)
    ev_upd |=> upd_q == $past(cto)); // R5
  AST_CELL_XFER: assert property (@(posedge wrck) disable iff (!wrstn)
    ev_xfer |=> cto == $past(upd_q)); // R11
  AST_CELL_HOLD: assert property (@(posedge wrck) disable iff (!wrstn)
    !(ev_cap || ev_sh || ev_xfer) |=> $stable(cto)); // R12
endmodule

// File: rtl/core_wrapper_serial.sv
module core_wrapper_serial
  import cw_pkg::*;
#(
  parameter int               N_IN     = 4,
  parameter int               N_OUT    = 4,
  parameter logic [N_OUT-1:0] SAFE_VAL = '0,
  parameter logic [IR_W-1:0]  CAPT_PAT = 3'b110
) (
  input  logic             wrck,
  input  logic             wrstn,
  input  logic             sel_ir,
  input  logic             capture_wr,
  input  logic             shift_wr,
  input  logic             update_wr,
  input  logic             transfer_wr,
  input  logic             wsi,
  output logic             wso,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out
);
  localparam int N_CELL = N_IN + N_OUT;

  // Strobe qualification: exactly one strobe may act.
  logic [3:0] strobes;
  logic       lone;
  logic       multi;
  assign strobes = {capture_wr, shift_wr, update_wr, transfer_wr};
  assign lone    = lone_strobe(strobes);
  assign multi   = strobe_count(strobes) > 1;

  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_q;
  logic            chain_sel;
  logic            drv_pins;
  logic            drv_core;
  logic            safe_mode;

  assign chain_sel = uses_chain(ir_q);
  assign drv_pins  = drives_pins(ir_q);
  assign drv_core  = drives_core(ir_q);
  assign safe_mode = is_safe(ir_q);

  // Named event wires.
  logic ir_cap, ir_sh_ev, ir_upd;
  logic br_cap, br_sh, br_upd, br_xfer;
  logic by_cap, by_sh;

  assign ir_cap   = sel_ir & lone & capture_wr;
  assign ir_sh_ev = sel_ir & lone & shift_wr;
  assign ir_upd   = sel_ir & lone & update_wr;
  assign br_cap   = !sel_ir & chain_sel & lone & capture_wr;
  assign br_sh    = !sel_ir & chain_sel & lone & shift_wr;
  assign br_upd   = !sel_ir & chain_sel & lone & update_wr;
  assign br_xfer  = !sel_ir & chain_sel & lone & transfer_wr;
  assign by_cap   = !sel_ir & !chain_sel & lone & capture_wr;
  assign by_sh    = !sel_ir & !chain_sel & lone & shift_wr;

  cw_instr_reg #(.CAPT_PAT(CAPT_PAT)) u_ir (
    .wrck   (wrck),
    .wrstn  (wrstn),
    .ev_cap (ir_cap),
    .ev_sh  (ir_sh_ev),
    .ev_upd (ir_upd),
    .wsi    (wsi),
    .ir_sh  (ir_sh),
    .ir_q   (ir_q)
  );

  logic byp_q;
  cw_bypass_bit u_byp (
    .wrck   (wrck),
    .wrstn  (wrstn),
    .ev_cap (by_cap),
    .ev_sh  (by_sh),
    .wsi    (wsi),
    .byp_q  (byp_q)
  );

  // Boundary chain: link[0] is wsi, link[k+1] is the shift storage of cell k.
  logic [N_CELL:0]   link;
  logic [N_CELL-1:0] upd_bits;
  assign link[0] = wsi;

  for (genvar k = 0; k < N_CELL; k++) begin : g_cell
    if (k < N_IN) begin : g_in
      cw_cell u_cell (
        .wrck       (wrck),
        .wrstn      (wrstn),
        .cti        (link[k]),
        .cfi        (pin_in[k]),
        .ev_cap     (br_cap),
        .ev_sh      (br_sh),
        .ev_upd     (br_upd),
        .ev_xfer    (br_xfer),
        .drive      (drv_core),
        .cap_cfo    (drv_core),
        .force_safe (1'b0),
        .safe_bit   (1'b0),
        .cfo        (core_in[k]),
        .cto        (link[k+1]),
        .upd_q      (upd_bits[k])
      );
    end else begin : g_out
      localparam int J = k - N_IN;
      cw_cell u_cell (
        .wrck       (wrck),
        .wrstn      (wrstn),
        .cti        (link[k]),
        .cfi        (core_out[J]),
        .ev_cap     (br_cap),
        .ev_sh      (br_sh),
        .ev_upd     (br_upd),
        .ev_xfer    (br_xfer),
        .drive      (drv_pins),
        .cap_cfo    (drv_pins),
        .force_safe (safe_mode),
        .safe_bit   (SAFE_VAL[J]),
        .cfo        (pin_out[J]),
        .cto        (link[k+1]),
        .upd_q      (upd_bits[k])
      );
    end
  end

  // Serial output, retimed on the falling edge.
  logic so_next;
  always_comb begin
    if (sel_ir)         so_next = ir_sh[0];
    else if (chain_sel) so_next = link[N_CELL];
    else                so_next = byp_q;
  end

  always_ff @(negedge wrck or negedge wrstn) begin
    if (!wrstn) wso <= 1'b0;
    else        wso <= so_next;
  end

  AST_NO_COLLISION_EFFECT: assert property (@(posedge wrck) disable iff (!wrstn)
    multi |=> $stable(ir_q) && $stable(ir_sh) && $stable(byp_q)
              && $stable(link[N_CELL:1]) && $stable(upd_bits)); // R12
  AST_SAFE_PINS: assert property (@(posedge wrck) disable iff (!wrstn)
    (ir_q == OP_SAFE) |-> (pin_out == SAFE_VAL) && (core_in == pin_in)); // R10
  AST_TRANSPARENT: assert property (@(posedge wrck) disable iff (!wrstn)
    (ir_q == OP_BYPASS || ir_q == OP_PRELOAD) |->
      (core_in == pin_in) && (pin_out == core_out)); // R3
  AST_CLAMP_HOLD: assert property (@(posedge wrck) disable iff (!wrstn)
    (ir_q == OP_CLAMP) && $stable(ir_q) |-> $stable(pin_out)); // R9
  AST_SHIFT_KEEPS_PINS: assert property (@(posedge wrck) disable iff (!wrstn)
    br_sh && drv_pins |=> $stable(pin_out)); // R5
endmodule

// File: tb/sim_core_wrapper_serial.sv
module sim_core_wrapper_serial;
  localparam int         NI   = 3;
  localparam int         NO   = 3;
  localparam int         NC   = NI + NO;
  localparam logic [2:0] SAFE = 3'b101;
  localparam logic [2:0] CAP  = 3'b110;

  logic          wrck = 1'b0;
  logic          wrstn = 1'b0;
  logic          sel_ir = 1'b0;
  logic          capture_wr = 1'b0, shift_wr = 1'b0, update_wr = 1'b0, transfer_wr = 1'b0;
  logic          wsi = 1'b0;
  logic          wso;
  logic [NI-1:0] pin_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] pin_out;

  int n_run = 0;
  int n_fail = 0;

  always #2 wrck = ~wrck;

  core_wrapper_serial #(.N_IN(NI), .N_OUT(NO), .SAFE_VAL(SAFE), .CAPT_PAT(CAP)) u0 (
    .wrck(wrck), .wrstn(wrstn), .sel_ir(sel_ir), .capture_wr(capture_wr),
    .shift_wr(shift_wr), .update_wr(update_wr), .transfer_wr(transfer_wr),
    .wsi(wsi), .wso(wso), .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic c, input logic s, input logic u, input logic x);
    @(negedge wrck); #1;
    capture_wr = c; shift_wr = s; update_wr = u; transfer_wr = x;
    @(posedge wrck); #1;
    capture_wr = 0; shift_wr = 0; update_wr = 0; transfer_wr = 0;
  endtask

  task automatic scan_ir(input logic [2:0] op, output logic [2:0] got);
    @(negedge wrck); #1; sel_ir = 1;
    pulse(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge wrck); #1;
      got[i] = wso; wsi = op[i]; shift_wr = 1;
      @(posedge wrck); #1; shift_wr = 0;
    end
    pulse(0, 0, 1, 0);
    sel_ir = 0;
  endtask

  task automatic scan_dr(input logic [NC-1:0] v, input int len, input bit cap,
                         output logic [NC-1:0] got);
    got = '0;
    if (cap) pulse(1, 0, 0, 0);
    for (int i = 0; i < len; i++) begin
      @(negedge wrck); #1;
      got[len-1-i] = wso; wsi = v[len-1-i]; shift_wr = 1;
      @(posedge wrck); #1; shift_wr = 0;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0]    g3;
    logic [NC-1:0] g;
    logic [NC-1:0] v;

    // R1 reset state
    pin_in = 3'b011; core_out = 3'b100;
    repeat (3) @(posedge wrck);
    #1;
    chk("R1 wso reset", {7'b0, wso}, 8'h0);
    chk("R1 core_in transparent", {5'b0, core_in}, {5'b0, pin_in});
    chk("R1 pin_out transparent", {5'b0, pin_out}, {5'b0, core_out});
    @(negedge wrck); #1; wrstn = 1;

    // R2 instruction capture pattern
    scan_ir(3'b000, g3);
    chk("R2 ir capture", {5'b0, g3}, {5'b0, CAP});

    // R3 bypass: sweep functional paths and bypass scan
    for (int a = 0; a < 8; a++) begin
      pin_in = a[2:0]; core_out = ~a[2:0]; #1;
      chk("R3 core_in", {5'b0, core_in}, {5'b0, pin_in});
      chk("R3 pin_out", {5'b0, pin_out}, {5'b0, core_out});
    end
    v = 6'b101101;
    scan_dr(v, NC, 1, g);
    chk("R3 bypass path", {2'b0, g}, {2'b0, v >> 1});

    // R6 EXTEST sweep, R4 chain order, R5 update
    scan_ir(3'b001, g3);
    for (int p = 0; p < 8; p++) begin
      pin_in = ~p[2:0];
      scan_dr({p[2:0], 3'b000}, NC, 1, g);
      pulse(0, 0, 1, 0);
      core_out = p[2:0] ^ 3'b011; #1;
      chk("R6 pin_out from update", {5'b0, pin_out}, {5'b0, p[2:0]});
      scan_dr('0, NC, 1, g);
      chk("R4 R6 capture order", {2'b0, g}, {2'b0, p[2:0], ~p[2:0]});
      chk("R5 shift keeps pins", {5'b0, pin_out}, {5'b0, p[2:0]});
    end

    // R12 collisions: shift storage is 0, pins hold 7
    wsi = 1;
    pulse(0, 1, 1, 0);
    pulse(1, 0, 1, 0);
    pulse(0, 1, 0, 1);
    chk("R12 pins unchanged", {5'b0, pin_out}, 8'h07);
    scan_dr('0, NC, 0, g);
    chk("R12 chain unchanged", {2'b0, g}, 8'h00);

    // R11 transfer
    scan_dr(6'b010110, NC, 1, g);
    pulse(0, 0, 1, 0);
    scan_dr(6'b101001, NC, 0, g);
    chk("R5 pins hold during shift", {5'b0, pin_out}, 8'h02);
    pulse(0, 0, 0, 1);
    chk("R11 pins after transfer", {5'b0, pin_out}, 8'h02);
    scan_dr('0, NC, 0, g);
    chk("R11 transfer readback", {2'b0, g}, 8'h16);

    // R7 INTEST sweep
    scan_ir(3'b010, g3);
    for (int a = 0; a < 8; a++) begin
      scan_dr({3'b000, a[2:0]}, NC, 1, g);
      pulse(0, 0, 1, 0);
      core_out = a[2:0] ^ 3'b101; #1;
      chk("R7 core_in from update", {5'b0, core_in}, {5'b0, a[2:0]});
      scan_dr('0, NC, 1, g);
      chk("R7 capture", {2'b0, g}, {2'b0, a[2:0] ^ 3'b101, a[2:0]});
    end

    // R8 PRELOAD
    scan_ir(3'b011, g3);
    scan_dr(6'b110001, NC, 1, g);
    pulse(0, 0, 1, 0);
    pin_in = 3'b010; core_out = 3'b001; #1;
    chk("R8 core_in transparent", {5'b0, core_in}, 8'h02);
    chk("R8 pin_out transparent", {5'b0, pin_out}, 8'h01);
    scan_dr('0, NC, 1, g);
    chk("R8 capture", {2'b0, g}, 8'h0A);

    // R9 CLAMP
    scan_ir(3'b100, g3);
    chk("R9 pins clamped", {5'b0, pin_out}, 8'h06);
    chk("R9 core_in transparent", {5'b0, core_in}, 8'h02);
    v = 6'b011011;
    scan_dr(v, NC, 1, g);
    chk("R9 bypass path", {2'b0, g}, {2'b0, v >> 1});

    // R10 SAFE
    scan_ir(3'b101, g3);
    for (int a = 0; a < 8; a++) begin
      core_out = a[2:0]; pin_in = ~a[2:0]; #1;
      chk("R10 safe pins", {5'b0, pin_out}, {5'b0, SAFE});
      chk("R10 core_in", {5'b0, core_in}, {5'b0, pin_in});
    end
    v = 6'b110010;
    scan_dr(v, NC, 1, g);
    chk("R10 bypass path", {2'b0, g}, {2'b0, v >> 1});

    // R2 unused opcode acts as bypass
    scan_ir(3'b111, g3);
    chk("R2 unused pin_out", {5'b0, pin_out}, {5'b0, core_out});
    v = 6'b100111;
    scan_dr(v, NC, 1, g);
    chk("R2 unused bypass path", {2'b0, g}, {2'b0, v >> 1});

    // R13 wso timing: ir shift storage holds 111 after the last load
    @(negedge wrck); #1; sel_ir = 1;
    @(negedge wrck); #1;
    chk("R13 wso ir bit0", {7'b0, wso}, 8'h01);
    pulse(1, 0, 0, 0);
    chk("R13 wso holds at rising edge", {7'b0, wso}, 8'h01);
    @(negedge wrck); #1;
    chk("R13 wso at falling edge", {7'b0, wso}, {7'b0, CAP[0]});
    sel_ir = 0;

    // R1 asynchronous reset mid-cycle under EXTEST
    scan_ir(3'b001, g3);
    scan_dr(6'b101000, NC, 1, g);
    pulse(0, 0, 1, 0);
    core_out = 3'b010; #1;
    chk("R1 pre-reset extest", {5'b0, pin_out}, 8'h05);
    @(posedge wrck); #1; wrstn = 0; #0.5;
    chk("R1 async transparent", {5'b0, pin_out}, 8'h02);
    chk("R1 async wso", {7'b0, wso}, 8'h00);
    @(negedge wrck); #1; wrstn = 1;
    scan_dr(6'b000000, NC, 1, g);
    chk("R1 bypass after reset", {2'b0, g}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule